// File: doc/BRIEF.md
# Power-Managed Serial ADC Reader

This block is the host side of a three-wire link to a single-channel 12-bit serial converter. The converter has no ready flag and only listens. This controller supplies every clock edge and times every transaction from its own system clock. A client raises one of three one-cycle command strobes. A convert command pulses the active-low conversion-start line. It then waits a fixed number of cycles and opens a 16-clock read frame on the chip-select and serial-clock lines. The 16 data bits are shifted in most significant bit first. The low 12 bits come back on a result bus with a one-cycle valid strobe.

Power is managed only through frame timing. A sleep command opens a frame and closes chip-select after the sixth serial-clock falling edge. That edge lies in the middle of the window in which the converter drops into its low-power state. A wake command runs a full 16-clock dummy frame and throws its data away. After every frame, chip-select stays high for a quiet gap before the block accepts new work. The block keeps its own record of whether the converter sleeps, so commands that make no sense in that state are dropped.

States: `ST_IDLE` (waiting for a command), `ST_CONV` (start pulse and conversion wait), `ST_FRAME` (chip-select low, serial clock running), `ST_QUIET` (gap after a frame). Transitions: IDLE→CONV on an accepted convert, IDLE→FRAME on an accepted sleep or wake, CONV→FRAME when the wait count expires, FRAME→QUIET on the last rising edge of the frame, QUIET→IDLE when the gap count expires. The frame kind is read, sleep or dummy.

Top module: `adc_pm_reader`

## Requirements
- R1: After reset, cs_n, convst_n and sclk are high, and busy and result_valid are low.
- R2: An accepted convert drives convst_n low for CONVST_W cycles, starting the cycle after the strobe. busy is high from that cycle until the quiet gap ends.
- R3: cs_n falls exactly CONV_WAIT cycles after convst_n falls, and the two are never low together.
- R4: A read frame holds cs_n low for 32*SCLK_HALF cycles. It produces 16 sclk falling edges, with sclk high whenever cs_n is high and for the first SCLK_HALF cycles after cs_n falls.
- R5: SDATA is sampled on each sclk rising edge, most significant bit first. result equals the low 12 bits of the 16-bit word. result_valid is high for exactly one cycle, the cycle in which cs_n returns high.
- R6: After every frame, cs_n stays high and busy stays high for QUIET_CYC cycles, and busy then falls.
- R7: A sleep command while awake opens a frame with no convst_n pulse. The frame holds cs_n low for 12*SCLK_HALF cycles, with exactly 6 sclk falling edges, and gives no result_valid. The block is then asleep.
- R8: While asleep, convert and sleep commands are ignored: busy stays low and cs_n and convst_n stay high.
- R9: A wake command while asleep runs a frame of 16 falling edges with no convst_n pulse and no result_valid. A following convert then returns valid data.
- R10: Commands that arrive while busy is high are ignored.
- R11: When strobes coincide, wake beats sleep and sleep beats convert, among the commands valid in the current power state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_convert | input | 1 | One-cycle strobe: start a conversion and read it |
| cmd_sleep | input | 1 | One-cycle strobe: put the converter into low power |
| cmd_wake | input | 1 | One-cycle strobe: wake the converter with a dummy frame |
| sdata | input | 1 | Serial data from the converter |
| convst_n | output | 1 | Active-low conversion-start pulse |
| cs_n | output | 1 | Active-low chip-select |
| sclk | output | 1 | Serial clock, idles high |
| result | output | DATA_W | Last 12-bit conversion result |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| busy | output | 1 | High while a command is being carried out |

## Verification
The embedded properties hold on every cycle for the invariants that need no counting of frames. These are: sclk parked high outside frames, convst_n and cs_n never low together, a valid strobe one cycle long that falls only on a chip-select rising edge, no chip-select fall straight after a frame, and no conversion pulse while the converter sleeps. The exact cycle counts need the directed scenarios. These cover the conversion wait, the frame lengths, the number of falling edges (16 versus 6), the quiet gap, the bit order of the result, and the power-state bookkeeping. The scenarios also show the dropped commands and the priority rules, by watching busy and chip-select after each strobe.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_FRAME = 2'd2,
        ST_QUIET = 2'd3
    } rd_state_t;

    typedef enum logic [1:0] {
        FK_READ  = 2'd0,
        FK_SLEEP = 2'd1,
        FK_DUMMY = 2'd2
    } frame_kind_t;

endpackage

// File: rtl/adc_rd_sclk_gen.sv
module adc_rd_sclk_gen #(
    parameter int unsigned HALF_DIV = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_tick
);
    localparam int unsigned CW = (HALF_DIV < 2) ? 1 : $clog2(HALF_DIV);

    logic [CW-1:0] cnt;
    logic          half_end;

    assign half_end  = (cnt == CW'(HALF_DIV - 1));
    // this cycle ends a low half: sclk goes high at the coming edge
    assign rise_tick = run && half_end && !sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (!run) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (half_end) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> sclk); // R4

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int unsigned WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word_next
);
    logic [WIDTH-1:0] q;

    // leading bits of a longer frame fall off the top end
    assign word_next = {q[WIDTH-2:0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= word_next;
    end

endmodule

// File: rtl/adc_pm_reader.sv
module adc_pm_reader
    import adc_rd_pkg::*;
#(
    parameter int unsigned SCLK_HALF  = 14,
    parameter int unsigned CONVST_W   = 5,
    parameter int unsigned CONV_WAIT  = 330,
    parameter int unsigned QUIET_CYC  = 50,
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned SLEEP_EDGE = 6,
    parameter int unsigned DATA_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_convert,
    input  logic              cmd_sleep,
    input  logic              cmd_wake,
    input  logic              sdata,
    output logic              convst_n,
    output logic              cs_n,
    output logic              sclk,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              busy
);
    localparam int unsigned TMAX = (CONV_WAIT > QUIET_CYC) ? CONV_WAIT : QUIET_CYC;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned EW   = $clog2(FRAME_BITS + 1);

    rd_state_t     state, nxt_state;
    frame_kind_t   kind, nxt_kind;
    logic          asleep;
    logic [TW-1:0] tcnt;
    logic [EW-1:0] ecnt;
    logic [EW-1:0] edge_target;
    logic          rise_tick;
    logic          frame_done;
    logic [DATA_W-1:0] word_next;

    adc_rd_sclk_gen #(.HALF_DIV(SCLK_HALF)) u_sclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state == ST_FRAME),
        .sclk      (sclk),
        .rise_tick (rise_tick)
    );

    adc_rd_shifter #(.WIDTH(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (rise_tick),
        .din       (sdata),
        .word_next (word_next)
    );

    assign edge_target = (kind == FK_SLEEP) ? EW'(SLEEP_EDGE) : EW'(FRAME_BITS);
    assign frame_done  = (state == ST_FRAME) && rise_tick && (ecnt == edge_target - 1'b1);

    // next-state decode
    always_comb begin
        nxt_state = state;
        nxt_kind  = kind;
        unique case (state)
            ST_IDLE: begin
                if (cmd_wake && asleep) begin
                    nxt_state = ST_FRAME;
                    nxt_kind  = FK_DUMMY;
                end else if (cmd_sleep && !asleep) begin
                    nxt_state = ST_FRAME;
                    nxt_kind  = FK_SLEEP;
                end else if (cmd_convert && !asleep) begin
                    nxt_state = ST_CONV;
                    nxt_kind  = FK_READ;
                end
            end
            ST_CONV:  if (tcnt == TW'(CONV_WAIT - 1)) nxt_state = ST_FRAME;
            ST_FRAME: if (frame_done)                 nxt_state = ST_QUIET;
            ST_QUIET: if (tcnt == TW'(QUIET_CYC - 1)) nxt_state = ST_IDLE;
            default:  nxt_state = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            kind   <= FK_READ;
            asleep <= 1'b0;
            tcnt   <= '0;
            ecnt   <= '0;
        end else begin
            state <= nxt_state;
            kind  <= nxt_kind;
            tcnt  <= (nxt_state != state) ? '0 : tcnt + 1'b1;
            if (state != ST_FRAME) ecnt <= '0;
            else if (rise_tick)    ecnt <= ecnt + 1'b1;
            if (frame_done && kind == FK_SLEEP) asleep <= 1'b1;
            if (frame_done && kind == FK_DUMMY) asleep <= 1'b0;
        end
    end

    // pin outputs
    always_comb begin
        convst_n = !((state == ST_CONV) && (tcnt < TW'(CONVST_W)));
        cs_n     = (state != ST_FRAME);
        busy     = (state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= frame_done && (kind == FK_READ);
            if (frame_done && kind == FK_READ) result <= word_next;
        end
    end

    AST_CONVST_CS_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !convst_n |-> cs_n); // R3
    AST_CS_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk); // R4
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R5
    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(cs_n)); // R5
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n); // R6
    AST_BUSY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n || !convst_n) |-> busy); // R2
    AST_ASLEEP_NO_CONVST: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> convst_n); // R8

endmodule

// File: tb/tb_adc_pm_reader.sv
module tb_adc_pm_reader;
    localparam int HALF  = 2;
    localparam int CVW   = 3;
    localparam int CWAIT = 20;
    localparam int QCYC  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_convert = 1'b0, cmd_sleep = 1'b0, cmd_wake = 1'b0;
    logic sdata = 1'b0;
    logic convst_n, cs_n, sclk, result_valid, busy;
    logic [11:0] result;

    int checks = 0, fails = 0, cyc = 0;

    adc_pm_reader #(.SCLK_HALF(HALF), .CONVST_W(CVW), .CONV_WAIT(CWAIT),
                    .QUIET_CYC(QCYC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_convert(cmd_convert), .cmd_sleep(cmd_sleep),
        .cmd_wake(cmd_wake), .sdata(sdata), .convst_n(convst_n), .cs_n(cs_n),
        .sclk(sclk), .result(result), .result_valid(result_valid), .busy(busy));

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // converter model: next bit presented on each sclk falling edge
    logic [15:0] tx_word = 16'h0000;
    int bit_idx = 15;
    int nfall = 0;
    always @(negedge cs_n) begin
        bit_idx = 15;
        nfall = 0;
    end
    always @(negedge sclk) begin
        if (!cs_n) begin
            nfall = nfall + 1;
            if (bit_idx >= 0) begin
                sdata = tx_word[bit_idx];
                bit_idx = bit_idx - 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // observation results
    int n_cv, i_cv, i_cs, n_cs, n_csfall, n_val, i_cslast, i_qend;
    bit saw_busy, sclk_at_cs;
    logic [11:0] got;

    task automatic observe(input int limit, input int inj_idx);
        bit prev_cs = 1'b1;
        n_cv = 0; i_cv = -1; i_cs = -1; n_cs = 0; n_csfall = 0; n_val = 0;
        i_cslast = -1; i_qend = -1; saw_busy = 0; sclk_at_cs = 0; got = '0;
        for (int idx = 0; idx < limit; idx++) begin
            if (idx == inj_idx) cmd_sleep = 1'b1;
            if (idx == inj_idx + 1) cmd_sleep = 1'b0;
            if (!convst_n) begin
                n_cv++;
                if (i_cv < 0) i_cv = idx;
            end
            if (!cs_n) begin
                n_cs++;
                i_cslast = idx;
                if (i_cs < 0) begin
                    i_cs = idx;
                    sclk_at_cs = sclk;
                end
            end
            if (!cs_n && prev_cs) n_csfall++;
            prev_cs = cs_n;
            if (result_valid) begin
                n_val++;
                got = result;
            end
            if (busy) saw_busy = 1'b1;
            if (saw_busy && !busy) begin
                i_qend = idx;
                break;
            end
            @(negedge clk);
        end
        cmd_sleep = 1'b0;
    endtask

    task automatic strobe(input bit cv, input bit sl, input bit wk);
        @(negedge clk);
        cmd_convert = cv; cmd_sleep = sl; cmd_wake = wk;
        @(negedge clk);
        cmd_convert = 1'b0; cmd_sleep = 1'b0; cmd_wake = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cs_n && convst_n && sclk, "R1", "pins high after reset", {cs_n, convst_n, sclk}, 7);
        check(!busy && !result_valid, "R1", "busy/valid low after reset", {busy, result_valid}, 0);
    endtask

    task automatic t_read(input logic [15:0] w, input int inj);
        tx_word = w;
        strobe(1, 0, 0);
        observe(2000, inj);
        check(i_cv == 0, "R2", "convst_n fall index", i_cv, 0);
        check(n_cv == CVW, "R2", "convst_n low cycles", n_cv, CVW);
        check(i_cs - i_cv == CWAIT, "R3", "convst to cs delay", i_cs - i_cv, CWAIT);
        check(n_cs == 32 * HALF, "R4", "cs low cycles", n_cs, 32 * HALF);
        check(nfall == 16, "R4", "sclk falling edges", nfall, 16);
        check(sclk_at_cs, "R4", "sclk high at cs fall", sclk_at_cs, 1);
        check(n_val == 1, "R5", "valid pulses", n_val, 1);
        check(got == w[11:0], "R5", "result word", got, w[11:0]);
        check(i_qend - (i_cslast + 1) == QCYC, "R6", "quiet gap", i_qend - (i_cslast + 1), QCYC);
    endtask

    task automatic t_sleep(input bit with_convert);
        strobe(with_convert, 1, 0);
        observe(2000, -1);
        check(n_cv == 0, with_convert ? "R11" : "R7", "no convst in sleep frame", n_cv, 0);
        check(n_cs == 12 * HALF, "R7", "sleep cs low cycles", n_cs, 12 * HALF);
        check(nfall == 6, with_convert ? "R11" : "R7", "sleep falling edges", nfall, 6);
        check(n_val == 0, "R7", "no valid in sleep frame", n_val, 0);
        check(i_qend - (i_cslast + 1) == QCYC, "R6", "quiet after sleep", i_qend - (i_cslast + 1), QCYC);
    endtask

    task automatic t_ignored_asleep();
        strobe(1, 0, 0);
        observe(40, -1);
        check(!saw_busy && n_cs == 0 && n_cv == 0, "R8", "convert ignored asleep", n_cs + n_cv, 0);
        strobe(0, 1, 0);
        observe(40, -1);
        check(!saw_busy && n_cs == 0, "R8", "sleep ignored asleep", n_cs, 0);
    endtask

    task automatic t_wake(input bit with_convert);
        tx_word = 16'h0FFF;
        strobe(with_convert, 0, 1);
        observe(2000, -1);
        check(n_cv == 0, with_convert ? "R11" : "R9", "no convst in dummy frame", n_cv, 0);
        check(nfall == 16, "R9", "dummy falling edges", nfall, 16);
        check(n_val == 0, "R9", "dummy data discarded", n_val, 0);
    endtask

    task automatic t_busy_ignore();
        // sleep strobe injected while the read frame runs
        t_read(16'h0123, CWAIT + 10);
        check(n_csfall == 1, "R10", "single frame despite sleep", n_csfall, 1);
        t_read(16'h0456, -1);
        check(n_val == 1, "R10", "still awake after ignored sleep", n_val, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read(16'h0ABC, -1);
        t_read(16'hF555, -1);
        t_read(16'h0000, -1);
        t_busy_ignore();
        t_sleep(0);
        t_ignored_asleep();
        t_wake(0);
        t_read(16'h0A5A, -1);
        check(got == 12'hA5A, "R9", "valid data after wake", got, 12'hA5A);
        t_sleep(1);
        t_wake(1);
        t_read(16'h0321, -1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule